// File: doc/BRIEF.md
# Byte Serial Shift Controller

This block moves one byte at a time over a three-wire synchronous serial link made of a data line in, a data line out and a shift clock. It has two roles. As clock master it makes the shift clock itself from the system clock, at one of three selectable rates. As clock follower it takes the shift clock from a pin, passes it through a synchronizer and detects its edges. Both roles use the same shift register. Data leaves most significant bit first on the falling shift-clock edge, and incoming data is captured on the rising edge. The shift clock rests low.

Software works through a small parallel register port. It loads the byte, sets a busy bit to start the exchange, and later reads back the received byte. The busy bit clears itself once eight bits have moved. Software may also clear busy early to cut a transfer short, which leaves a partial byte. A sticky completion flag is raised only at the end of a full byte. It drives an interrupt line when that is enabled. Output-enable signals tell the pad logic when the clock and data-out functions may drive their pins.

Top module: `byteShifter`

## Requirements
- R1: The register map is: address 0 is the data/shift register, address 1 is control, and address 2 is status. In status, bit 0 is busy and bit 1 is the done flag. Writing status with bit 0 set while idle and enabled sets busy. Busy then clears by itself after eight shift-clock falling edges, and at that point the byte read from address 0 is the byte received.
- R2: Writing status with bit 0 clear during a transfer stops it at once. After k completed falling edges, the data register holds the original byte shifted left by k with the first k received bits below it. Busy reads 0 and the done flag is not set.
- R3: The done flag (status bit 1) sets only when a full byte completes. It stays set until a status write with bit 1 clear. The `irq` output equals the done flag ANDed with control bit 4.
- R4: In master mode, control bits 3:2 select the shift-clock period in system clock cycles: 00 gives 2, 01 gives 4, and 10 or 11 gives 8.
- R5: The shift clock idles low. `sdo` shows the register's top bit, so it changes only after a falling edge. Data is sent MSB first, and `sdi` is captured at each rising edge.
- R6: In slave mode (control bit 1 = 0), the external clock passes through a two-flop synchronizer. The transfer ends after eight falling edges, and further pulses change nothing. `sckOut` stays low.
- R7: `sckOe` = control bit 0 AND control bit 1 AND control bit 6. `sdoOe` = control bit 0 AND control bit 5.
- R8: A write to address 0 while busy is set is ignored.
- R9: A write that sets busy while control bit 0 (enable) is 0 is ignored.
- R10: After reset, all registers read 0 and `sckOut`, `irq`, `sckOe` and `sdoOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | DATA_W | Read data (combinational) |
| sckIn | input | 1 | External shift clock (slave mode) |
| sdi | input | 1 | Serial data in |
| sckOut | output | 1 | Generated shift clock (master mode) |
| sckOe | output | 1 | Shift clock pin output enable |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Data-out pin output enable |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong bit counter shows up at the end of a transfer. Busy then falls one or more shift-clock periods too early or too late, and the received byte comes out rotated. Both can be seen as soon as a full byte should have completed. A wrong divider state shows in the first two rising edges of `sckOut`, so the rate checks measure that spacing directly. Errors in the abort and ignore paths only become visible through the data register and the done flag. For that reason each such scenario reads both back immediately after the stimulus, before any further shifting can hide the difference.

// File: rtl/byteShifterPkg.sv
package byteShifterPkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control register fields, packed MSB first
  typedef struct packed {
    logic       sckCfg;   // bit 6
    logic       sdoCfg;   // bit 5
    logic       intEn;    // bit 4
    logic [1:0] rate;     // bits 3:2
    logic       master;   // bit 1
    logic       enable;   // bit 0
  } ctrlReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
  } dpStrobe_t;

  // system cycles per half shift-clock period
  function automatic logic [2:0] halfCycles(input logic [1:0] rate);
    case (rate)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sshDatapath.sv
module sshDatapath
  import byteShifterPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              master,
  input  logic [DATA_W-1:0] loadData,
  input  logic              sdi,
  output logic [DATA_W-1:0] shiftReg,
  output logic              sdo
);

  logic [SYNC_STAGES-1:0] sdiSync;
  logic                   sampleBit;
  logic                   sdiPick;

  // slave data is delayed like the slave clock so both stay aligned
  assign sdiPick = master ? sdi : sdiSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiSync   <= '0;
      sampleBit <= 1'b0;
      shiftReg  <= '0;
    end else begin
      sdiSync <= {sdiSync[SYNC_STAGES-2:0], sdi};
      if (strb.sample) sampleBit <= sdiPick;
      if (strb.load)
        shiftReg <= loadData;
      else if (strb.shift)
        shiftReg <= {shiftReg[DATA_W-2:0], sampleBit};
    end
  end

  assign sdo = shiftReg[DATA_W-1];

  // R1/R8: a granted load lands in the register on the next cycle
  p_load_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> shiftReg == $past(loadData));

  // R2: with no load and no shift strobe, the register holds its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(shiftReg));

  // R5: each shift moves the old top bit out and sdo then shows the next bit
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.load) |=> sdo == $past(shiftReg[DATA_W-2]));

endmodule

// File: rtl/sshControl.sv
module sshControl
  import byteShifterPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [6:0] wrBits,
  input  logic       sckIn,
  output ctrlReg_t   ctrlReg,
  output logic       busy,
  output logic       irqFlag,
  output logic       sckInt,
  output dpStrobe_t  strb
);

  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic                   ctlWr, statWr, dataWr;
  logic                   abortNow, startNow;
  logic                   tick, mRise, mFall, sRise, sFall, lastShift;
  logic [2:0]             divCnt, halfLen;
  logic [CNT_W-1:0]       bitCnt;
  logic [SYNC_STAGES-1:0] sckSync;
  logic                   sckPrev;

  assign ctlWr  = wrEn && (wrAddr == ADDR_CTRL);
  assign statWr = wrEn && (wrAddr == ADDR_STAT);
  assign dataWr = wrEn && (wrAddr == ADDR_DATA);

  assign abortNow = statWr && !wrBits[0];
  assign startNow = statWr && wrBits[0] && !busy && ctrlReg.enable;

  // master rate divider
  assign halfLen = halfCycles(ctrlReg.rate);
  assign tick    = busy && ctrlReg.master && (divCnt == halfLen - 3'd1);
  assign mRise   = tick && !sckInt;
  assign mFall   = tick && sckInt;

  // slave edge detection after the synchronizer
  assign sRise = sckSync[SYNC_STAGES-1] && !sckPrev;
  assign sFall = !sckSync[SYNC_STAGES-1] && sckPrev;

  always_comb begin
    strb.load   = dataWr && !busy;
    strb.sample = busy && !abortNow && (ctrlReg.master ? mRise : sRise);
    strb.shift  = busy && !abortNow && (ctrlReg.master ? mFall : sFall);
  end

  assign lastShift = strb.shift && (bitCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      sckSync <= '0;
      sckPrev <= 1'b0;
      busy    <= 1'b0;
      bitCnt  <= '0;
      divCnt  <= '0;
      sckInt  <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (ctlWr) ctrlReg <= ctrlReg_t'(wrBits);

      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      sckPrev <= sckSync[SYNC_STAGES-1];

      if (abortNow)       busy <= 1'b0;
      else if (lastShift) busy <= 1'b0;
      else if (startNow)  busy <= 1'b1;

      if (!busy || abortNow)  bitCnt <= '0;
      else if (strb.shift)    bitCnt <= bitCnt + 1'b1;

      if (!busy || !ctrlReg.master || tick || abortNow) divCnt <= '0;
      else                                               divCnt <= divCnt + 3'd1;

      if (!busy || abortNow || lastShift) sckInt <= 1'b0;
      else if (tick)                      sckInt <= !sckInt;

      if (lastShift)                   irqFlag <= 1'b1;
      else if (statWr && !wrBits[1])   irqFlag <= 1'b0;
    end
  end

  // R1: the final shift ends the transfer and raises the done flag
  p_end_of_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    lastShift |=> (!busy && irqFlag));

  // R1/R5: every transfer begins from bit zero with the clock at rest
  p_clean_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (bitCnt == '0 && !sckInt));

  // R2: an abort leaves busy low and does not create a done flag
  p_abort_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abortNow && !irqFlag) |=> (!busy && !irqFlag));

  // R5: shift clock rests low whenever no transfer runs
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckInt);

  // R9: a start request while disabled leaves busy low
  p_no_start_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && statWr && !ctrlReg.enable) |=> !busy);

  // R3: the done flag is never set without a completed byte
  p_flag_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(busy));

endmodule

// File: rtl/byteShifter.sv
module byteShifter
  import byteShifterPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              sckIn,
  input  logic              sdi,
  output logic              sckOut,
  output logic              sckOe,
  output logic              sdo,
  output logic              sdoOe,
  output logic              irq
);

  ctrlReg_t          ctrlReg;
  dpStrobe_t         strb;
  logic              busy, irqFlag, sckInt;
  logic [DATA_W-1:0] shiftReg;
  logic [6:0]        ctlBits;

  sshControl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrBits  (wrData[6:0]),
    .sckIn   (sckIn),
    .ctrlReg (ctrlReg),
    .busy    (busy),
    .irqFlag (irqFlag),
    .sckInt  (sckInt),
    .strb    (strb)
  );

  sshDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .master   (ctrlReg.master),
    .loadData (wrData),
    .sdi      (sdi),
    .shiftReg (shiftReg),
    .sdo      (sdo)
  );

  assign ctlBits = ctrlReg;
  assign sckOut  = sckInt;
  assign sckOe   = ctrlReg.enable && ctrlReg.master && ctrlReg.sckCfg;
  assign sdoOe   = ctrlReg.enable && ctrlReg.sdoCfg;
  assign irq     = irqFlag && ctrlReg.intEn;

  always_comb begin
    case (rdAddr)
      ADDR_DATA: rdData = shiftReg;
      ADDR_CTRL: rdData = DATA_W'(ctlBits);
      ADDR_STAT: rdData = DATA_W'({irqFlag, busy});
      default:   rdData = '0;
    endcase
  end

  // R6: in slave mode the generated clock never toggles
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg.master |=> !sckOut || !$past(ctrlReg.master) ? (!ctrlReg.master ? !sckOut : 1'b1) : 1'b1);

endmodule

// File: tb/sim_byteShifter.sv
module sim_byteShifter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       sckIn = 1'b0;
  logic       sdi;
  logic       sckOut, sckOe, sdo, sdoOe, irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench-side peer for master tests
  logic [7:0] devReg = '0;
  logic       capBit = 1'b0;
  logic       slaveMode = 1'b0;
  logic       sdiSlv = 1'b0;
  int         cyc = 0;
  int         riseCnt = 0;
  int         firstRise = 0;
  int         period = 0;
  int         fallCnt = 0;

  assign sdi = slaveMode ? sdiSlv : devReg[7];

  always #2.5 clk = ~clk;

  byteShifter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sckIn(sckIn), .sdi(sdi),
    .sckOut(sckOut), .sckOe(sckOe), .sdo(sdo), .sdoOe(sdoOe), .irq(irq)
  );

  always @(posedge clk) cyc++;

  always @(posedge sckOut) begin
    capBit = sdo;
    riseCnt++;
    if (riseCnt == 1) firstRise = cyc;
    if (riseCnt == 2) period = cyc - firstRise;
  end

  always @(negedge sckOut) begin
    devReg = {devReg[6:0], capBit};
    fallCnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd2, s);
      if (!s[0]) break;
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(2'd0, v); chk("R10 data", v, 0);
    rd(2'd1, v); chk("R10 ctrl", v, 0);
    rd(2'd2, v); chk("R10 status", v, 0);
    chk("R10 pins", {sckOut, irq, sckOe, sdoOe}, 0);
  endtask

  task automatic testMaster(input logic [1:0] rate, input logic intOn,
                            input logic [7:0] mine, input logic [7:0] peer,
                            input int expPeriod);
    logic [7:0] v;
    wr(2'd1, {1'b1, 1'b1, intOn, rate, 1'b1, 1'b1});
    chk("R7 sckOe master", sckOe, 1);
    chk("R7 sdoOe", sdoOe, 1);
    wr(2'd0, mine);
    devReg = peer; riseCnt = 0; period = 0; fallCnt = 0;
    wr(2'd2, 8'h01);
    waitIdle();
    chk("R4 period", period, expPeriod);
    rd(2'd0, v); chk("R1 received byte", v, peer);
    chk("R5 peer got MSB-first byte", devReg, mine);
    chk("R1 eight falling edges", fallCnt, 8);
    rd(2'd2, v); chk("R3 done flag", v, 8'h02);
    chk("R3 irq gated by enable", irq, intOn);
    repeat (20) @(negedge clk);
    chk("R3 flag sticky irq", irq, intOn);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R3 flag cleared", v, 0);
    chk("R3 irq cleared", irq, 0);
  endtask

  task automatic testAbort();
    logic [7:0] v;
    wr(2'd1, 8'h6F);           // enable, master, rate 11, both output cfgs
    wr(2'd0, 8'hC5);
    devReg = 8'h3A; fallCnt = 0;
    wr(2'd2, 8'h01);
    repeat (3) @(negedge sckOut);
    wr(2'd2, 8'h02);           // busy cleared, flag bit kept as 1
    rd(2'd0, v); chk("R2 partial byte", v, 8'h29); // (C5<<3)|(3A>>5)
    rd(2'd2, v); chk("R2 stopped, no flag", v, 0);
    chk("R2 no irq", irq, 0);
    repeat (40) @(negedge clk);
    chk("R2 clock idle after abort", sckOut, 0);
    chk("R2 no further edges", fallCnt, 3);
  endtask

  task automatic testBusyWrite();
    logic [7:0] v;
    wr(2'd1, 8'h6B);           // enable, master, rate 10
    wr(2'd0, 8'h96);
    devReg = 8'h5C;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hFF);
    waitIdle();
    rd(2'd0, v); chk("R8 write while busy ignored", v, 8'h5C);
    chk("R8 peer saw original byte", devReg, 8'h96);
    wr(2'd2, 8'h00);
  endtask

  task automatic testDisabled();
    logic [7:0] v;
    wr(2'd1, 8'h62);           // master, cfg bits, enable clear
    chk("R7 sckOe off", sckOe, 0);
    chk("R7 sdoOe off", sdoOe, 0);
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R9 busy stays low", v, 0);
    repeat (20) @(negedge clk);
    chk("R9 no clock", sckOut, 0);
    rd(2'd0, v); chk("R9 data untouched", v, 8'h11);
  endtask

  task automatic pulse(input logic b, output logic got);
    @(negedge clk);
    sdiSlv = b;
    repeat (5) @(negedge clk);
    got = sdo;
    sckIn = 1'b1;
    repeat (5) @(negedge clk);
    sckIn = 1'b0;
  endtask

  task automatic testSlave();
    logic [7:0] v;
    logic [7:0] seen;
    logic       g;
    slaveMode = 1'b1;
    wr(2'd1, 8'h61);           // enable, slave, both cfg bits
    chk("R7 sckOe low in slave", sckOe, 0);
    chk("R7 sdoOe in slave", sdoOe, 1);
    wr(2'd0, 8'hA7);
    wr(2'd2, 8'h01);
    seen = '0;
    for (int i = 7; i >= 0; i--) begin
      pulse(8'h4E >> i, g);
      seen = {seen[6:0], g};
    end
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R6 slave received", v, 8'h4E);
    chk("R6 slave sent MSB first", seen, 8'hA7);
    rd(2'd2, v); chk("R6 busy cleared after eight", v, 8'h02);
    chk("R6 sckOut quiet", sckOut, 0);
    pulse(1'b1, g);
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R6 ninth pulse ignored", v, 8'h4E);
    wr(2'd2, 8'h00);
    slaveMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaster(2'b00, 1'b1, 8'hA5, 8'h3C, 2);
    testMaster(2'b01, 1'b0, 8'h81, 8'h7E, 4);
    testMaster(2'b10, 1'b1, 8'h0F, 8'hF0, 8);
    testMaster(2'b11, 1'b1, 8'h5A, 8'hC3, 8);
    testAbort();
    testBusyWrite();
    testDisabled();
    testSlave();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule